// File: doc/BRIEF.md
# Speculative Return Stack with History Repair

This block sits in the branch prediction stage of one hardware thread. For every control instruction offered to it, the block gives back a predicted direction and next fetch address, and it keeps a return stack of call addresses. A call pushes the address of the call instruction itself. A return pops the top entry and targets that address plus one instruction step. In a delay-slot configuration the step is two instructions, so the return skips the slot. The direction prediction, the branch target buffer lookup and the direct branch target come from outside as inputs.

Each accepted prediction is appended to an in-order history queue under its sequence number. The history entry keeps the stack index and the top value seen at that moment. When a commit sequence number arrives, the oldest entries are retired one per cycle, and each retired entry sends a direction-update strobe. When a squash arrives, entries younger than the squash sequence number are removed one per cycle, youngest first, and their stack effects are undone exactly. A squash marked as a misprediction ends by sending a direction update and a target buffer update for the youngest surviving entry. That entry is then removed.

Top module: `spec_ret_stack`

## Requirements
- R1: After reset the history queue is empty, `hist_full` and `squash_busy` are low, and no update strobe is active. The stack top index and all stack entries are 0, so a return predicted straight after reset targets 0 plus one step.
- R2: A call, meaning `pred_is_call`=1 and `pred_is_ret`=0, pushes its own `pred_pc`. A taken return pops the stack and targets the popped value plus STEP, where STEP = INSN_BYTES*(1+DELAY_SLOT): 4 by default and 8 with a delay slot. Returns come back in last-in first-out order.
- R3: The predicted direction is `pred_uncond | pred_dir_taken`. The target is chosen in this priority order. If the branch is not taken, the target is `pred_pc`+STEP. A taken return uses the stack. A taken direct call uses `direct_target`. Any other taken branch uses `btb_target` on `btb_hit` and `pred_pc`+STEP on a miss.
- R4: The stack holds 16 entries and its index wraps. A 17th outstanding push overwrites the oldest entry. A pop from a logically empty stack returns whatever entry lies below the top, with no error.
- R5: The history queue holds 32 entries and `hist_full` is high while it is full. A prediction offered while the queue is full, or while `squash_busy` is high, is dropped: it leaves no history entry and has no effect on the stack.
- R6: A cycle with `commit_valid` records `commit_seq`. From the next cycle on, one oldest entry is retired per cycle while its sequence number is less than or equal to the recorded value. Each retirement raises `dir_upd_valid` with that entry's PC and predicted direction, oldest first.
- R7: A squash request (`squash_valid`) makes `squash_busy` high from the next cycle on. In each busy cycle the youngest entry is removed while its sequence number is greater than `squash_seq`. The cycle after the last removal is the final busy cycle, so with k younger entries the block is busy for k+1 cycles. No commit retirement happens while the block is busy.
- R8: In the final busy cycle of a squash with `squash_mispred`=1 and a non-empty queue, `dir_upd_valid` and `btb_upd_valid` are raised together. Both carry the PC of the youngest surviving entry, along with `squash_taken` and `squash_target`, and that entry is removed. A squash without the misprediction flag raises no strobe.
- R9: Removing a squashed return puts back the stack index and entry value that the return recorded. Removing a squashed call pops its push. After a squash, later return targets are the same as if the squashed predictions had never been made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request for a control instruction |
| pred_seq | input | 16 | Sequence number of the instruction |
| pred_pc | input | 32 | Instruction address |
| pred_is_call | input | 1 | Instruction is a call |
| pred_is_ret | input | 1 | Instruction is a return |
| pred_is_direct | input | 1 | Target is encoded in the instruction |
| pred_uncond | input | 1 | Unconditional control transfer |
| pred_dir_taken | input | 1 | Direction predictor says taken |
| btb_hit | input | 1 | Target buffer hit for this PC and address space |
| btb_target | input | 32 | Target from the target buffer |
| direct_target | input | 32 | Target decoded from the instruction |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next fetch address |
| hist_full | output | 1 | History queue full, prediction stalled |
| squash_busy | output | 1 | Squash walk in progress, prediction stalled |
| commit_valid | input | 1 | Commit point update |
| commit_seq | input | 16 | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 16 | Youngest surviving sequence number |
| squash_mispred | input | 1 | Squash caused by a resolved misprediction |
| squash_taken | input | 1 | Resolved direction |
| squash_target | input | 32 | Resolved target |
| dir_upd_valid | output | 1 | Direction predictor update strobe |
| dir_upd_pc | output | 32 | PC for the direction update |
| dir_upd_taken | output | 1 | Outcome for the direction update |
| btb_upd_valid | output | 1 | Target buffer update strobe |
| btb_upd_pc | output | 32 | PC for the target buffer update |
| btb_upd_target | output | 32 | Corrected target |

## Verification
The prediction outputs are combinational, so they are sampled in the same cycle as the request, before the capturing edge. Stack effects therefore show up on the very next prediction. Commit strobes start in the cycle right after the edge that captures `commit_seq` and continue one per cycle. A squash keeps `squash_busy` high for exactly the number of younger entries plus one cycle, and any misprediction update appears in the last of those cycles. The bench keeps its own queue of expected entries and walks these windows one falling edge at a time, checking every cycle, so an early, late, missing or extra strobe is caught.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    localparam int ADDR_W    = 32;
    localparam int SEQ_W     = 16;
    localparam int STK_DEPTH = 16;
    localparam int STK_IDX_W = $clog2(STK_DEPTH);

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [SEQ_W-1:0]     seq_t;
    typedef logic [STK_IDX_W-1:0] sidx_t;

    // one speculative prediction as logged for commit and repair
    typedef struct packed {
        seq_t  seq;
        addr_t pc;
        logic  taken;
        logic  used_stk;   // return: stk_idx/stk_val hold pre-pop state
        sidx_t stk_idx;
        addr_t stk_val;
        logic  was_call;   // call: undo by popping
    } hist_ent_t;
endpackage

// File: rtl/rsr_ret_stack.sv
module rsr_ret_stack
    import rsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_en,
    input  addr_t push_val,
    input  logic  pop_en,
    input  logic  restore_en,
    input  sidx_t restore_idx,
    input  addr_t restore_val,
    output sidx_t top_idx,
    output addr_t top_val
);
    typedef struct packed {
        sidx_t tos;
    } stk_state_t;

    stk_state_t s_d, s_q;
    addr_t      mem_q [STK_DEPTH];
    logic       wr_en;
    sidx_t      wr_idx;
    addr_t      wr_val;

    function automatic sidx_t idx_inc(input sidx_t i);
        return (i == sidx_t'(STK_DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic sidx_t idx_dec(input sidx_t i);
        return (i == '0) ? sidx_t'(STK_DEPTH - 1) : i - 1'b1;
    endfunction

    always_comb begin
        s_d    = s_q;
        wr_en  = 1'b0;
        wr_idx = idx_inc(s_q.tos);
        wr_val = push_val;
        if (restore_en) begin
            s_d.tos = restore_idx;
            wr_en   = 1'b1;
            wr_idx  = restore_idx;
            wr_val  = restore_val;
        end else if (push_en) begin
            s_d.tos = idx_inc(s_q.tos);
            wr_en   = 1'b1;
        end else if (pop_en) begin
            s_d.tos = idx_dec(s_q.tos);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < STK_DEPTH; i++) mem_q[i] <= '0;
        end else begin
            s_q <= s_d;
            if (wr_en) mem_q[wr_idx] <= wr_val;
        end
    end

    assign top_idx = s_q.tos;
    assign top_val = mem_q[s_q.tos];

    AST_STACK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_en, pop_en, restore_en})); // R9
    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en && !restore_en) |=> (top_val == $past(push_val))); // R2
    AST_RESTORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> (top_idx == $past(restore_idx) && top_val == $past(restore_val))); // R9
endmodule

// File: rtl/rsr_hist_queue.sv
module rsr_hist_queue
    import rsr_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_en,
    input  hist_ent_t push_ent,
    input  logic      pop_old_en,
    input  logic      pop_young_en,
    output hist_ent_t old_ent,
    output hist_ent_t young_ent,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } hq_state_t;

    hq_state_t        s_d, s_q;
    hist_ent_t        mem_q [DEPTH];
    logic [PTR_W-1:0] young_idx;

    function automatic logic [PTR_W-1:0] p_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] p_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        young_idx = p_dec(s_q.tail);
        if (push_en)      s_d.tail = p_inc(s_q.tail);
        if (pop_young_en) s_d.tail = young_idx;
        if (pop_old_en)   s_d.head = p_inc(s_q.head);
        s_d.cnt = s_q.cnt + CNT_W'(push_en) - CNT_W'(pop_old_en) - CNT_W'(pop_young_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_en) mem_q[s_q.tail] <= push_ent;
    end

    assign old_ent   = mem_q[s_q.head];
    assign young_ent = mem_q[young_idx];
    assign empty     = (s_q.cnt == '0);
    assign full      = (s_q.cnt == CNT_W'(DEPTH));

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !full); // R5
    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old_en || pop_young_en) |-> !empty); // R6
    AST_NO_PUSH_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        pop_young_en |-> !(push_en || pop_old_en)); // R7
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && !pop_old_en && !pop_young_en) |=> $stable(s_q.cnt)); // R5
endmodule

// File: rtl/spec_ret_stack.sv
module spec_ret_stack
    import rsr_pkg::*;
#(
    parameter int HQ_DEPTH   = 32,
    parameter int DELAY_SLOT = 0,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [SEQ_W-1:0]  pred_seq,
    input  logic [ADDR_W-1:0] pred_pc,
    input  logic              pred_is_call,
    input  logic              pred_is_ret,
    input  logic              pred_is_direct,
    input  logic              pred_uncond,
    input  logic              pred_dir_taken,
    input  logic              btb_hit,
    input  logic [ADDR_W-1:0] btb_target,
    input  logic [ADDR_W-1:0] direct_target,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic              hist_full,
    output logic              squash_busy,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              squash_mispred,
    input  logic              squash_taken,
    input  logic [ADDR_W-1:0] squash_target,
    output logic              dir_upd_valid,
    output logic [ADDR_W-1:0] dir_upd_pc,
    output logic              dir_upd_taken,
    output logic              btb_upd_valid,
    output logic [ADDR_W-1:0] btb_upd_pc,
    output logic [ADDR_W-1:0] btb_upd_target
);
    localparam addr_t STEP = ADDR_W'(INSN_BYTES * (1 + DELAY_SLOT));

    typedef struct packed {
        logic  sq_busy;
        seq_t  sq_seq;
        logic  sq_mis;
        logic  sq_taken;
        addr_t sq_tgt;
        logic  done_vld;
        seq_t  done_seq;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    logic      accept, hq_push, hq_pop_old, hq_pop_young, hq_empty, hq_full;
    hist_ent_t new_ent, old_ent, young_ent;
    logic      stk_push, stk_pop, stk_restore;
    sidx_t     stk_top_idx;
    addr_t     stk_top_val;

    always_comb begin
        s_d         = s_q;
        accept      = pred_valid && !hq_full && !s_q.sq_busy;
        pred_taken  = pred_uncond | pred_dir_taken;
        if (!pred_taken)                        pred_target = pred_pc + STEP;
        else if (pred_is_ret)                   pred_target = stk_top_val + STEP;
        else if (pred_is_call && pred_is_direct) pred_target = direct_target;
        else if (btb_hit)                       pred_target = btb_target;
        else                                    pred_target = pred_pc + STEP;

        new_ent = '{seq: pred_seq, pc: pred_pc, taken: pred_taken,
                    used_stk: pred_is_ret, stk_idx: stk_top_idx,
                    stk_val: stk_top_val, was_call: pred_is_call & ~pred_is_ret};

        hq_push        = accept;
        stk_push       = accept && pred_is_call && !pred_is_ret;
        stk_pop        = accept && pred_is_ret;
        stk_restore    = 1'b0;
        hq_pop_old     = 1'b0;
        hq_pop_young   = 1'b0;
        dir_upd_valid  = 1'b0;
        dir_upd_pc     = old_ent.pc;
        dir_upd_taken  = old_ent.taken;
        btb_upd_valid  = 1'b0;
        btb_upd_pc     = young_ent.pc;
        btb_upd_target = s_q.sq_tgt;

        if (s_q.sq_busy) begin
            if (!hq_empty && (young_ent.seq > s_q.sq_seq)) begin
                hq_pop_young = 1'b1;
                if (young_ent.used_stk)      stk_restore = 1'b1;
                else if (young_ent.was_call) stk_pop     = 1'b1;
            end else begin
                s_d.sq_busy = 1'b0;
                if (s_q.sq_mis && !hq_empty) begin
                    hq_pop_young  = 1'b1;
                    dir_upd_valid = 1'b1;
                    dir_upd_pc    = young_ent.pc;
                    dir_upd_taken = s_q.sq_taken;
                    btb_upd_valid = 1'b1;
                end
            end
        end else if (s_q.done_vld && !hq_empty && (old_ent.seq <= s_q.done_seq)) begin
            hq_pop_old    = 1'b1;
            dir_upd_valid = 1'b1;
        end

        if (commit_valid) begin
            s_d.done_vld = 1'b1;
            s_d.done_seq = commit_seq;
        end
        if (squash_valid) begin
            s_d.sq_busy  = 1'b1;
            s_d.sq_seq   = squash_seq;
            s_d.sq_mis   = squash_mispred;
            s_d.sq_taken = squash_taken;
            s_d.sq_tgt   = squash_target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hist_full   = hq_full;
    assign squash_busy = s_q.sq_busy;

    rsr_ret_stack u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_en     (stk_push),
        .push_val    (pred_pc),
        .pop_en      (stk_pop),
        .restore_en  (stk_restore),
        .restore_idx (young_ent.stk_idx),
        .restore_val (young_ent.stk_val),
        .top_idx     (stk_top_idx),
        .top_val     (stk_top_val)
    );

    rsr_hist_queue #(.DEPTH(HQ_DEPTH)) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_en      (hq_push),
        .push_ent     (new_ent),
        .pop_old_en   (hq_pop_old),
        .pop_young_en (hq_pop_young),
        .old_ent      (old_ent),
        .young_ent    (young_ent),
        .empty        (hq_empty),
        .full         (hq_full)
    );

    AST_BTB_ONLY_AT_SQUASH_END: assert property (@(posedge clk) disable iff (!rst_n)
        btb_upd_valid |=> !squash_busy || $past(squash_valid)); // R8
    AST_BTB_PAIRS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        btb_upd_valid |-> (dir_upd_valid && dir_upd_pc == btb_upd_pc)); // R8
    AST_NO_RETIRE_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_busy && !btb_upd_valid) |-> !dir_upd_valid); // R7
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_full && !hq_pop_old && !hq_pop_young) |=> hist_full); // R5
endmodule

// File: tb/spec_ret_stack_bench.sv
`timescale 1ns/1ps
module spec_ret_stack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid = 0, pred_is_call = 0, pred_is_ret = 0, pred_is_direct = 0;
    logic        pred_uncond = 0, pred_dir_taken = 0, btb_hit = 0;
    logic [15:0] pred_seq = '0;
    logic [31:0] pred_pc = '0, btb_target = '0, direct_target = '0;
    logic        commit_valid = 0, squash_valid = 0, squash_mispred = 0, squash_taken = 0;
    logic [15:0] commit_seq = '0, squash_seq = '0;
    logic [31:0] squash_target = '0;
    logic        pred_taken, hist_full, squash_busy, dir_upd_valid, dir_upd_taken, btb_upd_valid;
    logic [31:0] pred_target, dir_upd_pc, btb_upd_pc, btb_upd_target;
    logic        d_taken, d_full, d_busy, d_dv, d_dt, d_bv;
    logic [31:0] d_target, d_dpc, d_bpc, d_btgt;

    int tests = 0, fails = 0, cycles = 0;
    logic [15:0] seq_ctr = 16'd1;
    logic [31:0] mq_pc[$];
    logic        mq_tk[$];
    logic [15:0] mq_seq[$];

    always #2.5 clk = ~clk;

    spec_ret_stack u_spec_ret_stack (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_seq(pred_seq),
        .pred_pc(pred_pc), .pred_is_call(pred_is_call), .pred_is_ret(pred_is_ret),
        .pred_is_direct(pred_is_direct), .pred_uncond(pred_uncond),
        .pred_dir_taken(pred_dir_taken), .btb_hit(btb_hit), .btb_target(btb_target),
        .direct_target(direct_target), .pred_taken(pred_taken), .pred_target(pred_target),
        .hist_full(hist_full), .squash_busy(squash_busy), .commit_valid(commit_valid),
        .commit_seq(commit_seq), .squash_valid(squash_valid), .squash_seq(squash_seq),
        .squash_mispred(squash_mispred), .squash_taken(squash_taken),
        .squash_target(squash_target), .dir_upd_valid(dir_upd_valid),
        .dir_upd_pc(dir_upd_pc), .dir_upd_taken(dir_upd_taken),
        .btb_upd_valid(btb_upd_valid), .btb_upd_pc(btb_upd_pc),
        .btb_upd_target(btb_upd_target));

    spec_ret_stack #(.DELAY_SLOT(1)) u_ds (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_seq(pred_seq),
        .pred_pc(pred_pc), .pred_is_call(pred_is_call), .pred_is_ret(pred_is_ret),
        .pred_is_direct(pred_is_direct), .pred_uncond(pred_uncond),
        .pred_dir_taken(pred_dir_taken), .btb_hit(btb_hit), .btb_target(btb_target),
        .direct_target(direct_target), .pred_taken(d_taken), .pred_target(d_target),
        .hist_full(d_full), .squash_busy(d_busy), .commit_valid(commit_valid),
        .commit_seq(commit_seq), .squash_valid(squash_valid), .squash_seq(squash_seq),
        .squash_mispred(squash_mispred), .squash_taken(squash_taken),
        .squash_target(squash_target), .dir_upd_valid(d_dv), .dir_upd_pc(d_dpc),
        .dir_upd_taken(d_dt), .btb_upd_valid(d_bv), .btb_upd_pc(d_bpc),
        .btb_upd_target(d_btgt));

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one prediction; expected targets for step 4 and step 8 instances
    task automatic do_pred(input logic [31:0] pc, input logic c, r, d, u, t, h,
                           input logic [31:0] bt, dt, et, et_ds, input string req);
        @(negedge clk);
        pred_valid = 1; pred_pc = pc; pred_is_call = c; pred_is_ret = r;
        pred_is_direct = d; pred_uncond = u; pred_dir_taken = t; btb_hit = h;
        btb_target = bt; direct_target = dt; pred_seq = seq_ctr;
        #1;
        chk(pred_taken == (u | t), req, {31'd0, pred_taken}, {31'd0, u | t});
        chk(pred_target == et, req, pred_target, et);
        chk(d_target == et_ds, req, d_target, et_ds);
        chk(hist_full == (mq_pc.size() >= 32), "R5", {31'd0, hist_full}, {31'd0, mq_pc.size() >= 32});
        if (mq_pc.size() < 32) begin
            mq_pc.push_back(pc); mq_tk.push_back(u | t); mq_seq.push_back(seq_ctr);
            seq_ctr++;
        end
        @(posedge clk); #1;
        pred_valid = 0;
    endtask

    // R6: strobes start the cycle after the capturing edge, one per cycle
    task automatic commit_to(input logic [15:0] done);
        @(negedge clk);
        commit_valid = 1; commit_seq = done;
        @(posedge clk); #1;
        commit_valid = 0;
        while (mq_seq.size() > 0 && mq_seq[0] <= done) begin
            @(negedge clk);
            chk(dir_upd_valid == 1'b1, "R6", {31'd0, dir_upd_valid}, 32'd1);
            chk(dir_upd_pc == mq_pc[0], "R6", dir_upd_pc, mq_pc[0]);
            chk(dir_upd_taken == mq_tk[0], "R6", {31'd0, dir_upd_taken}, {31'd0, mq_tk[0]});
            void'(mq_pc.pop_front()); void'(mq_tk.pop_front()); void'(mq_seq.pop_front());
        end
        @(negedge clk);
        chk(dir_upd_valid == 1'b0, "R6", {31'd0, dir_upd_valid}, 32'd0);
    endtask

    // R7/R8: busy for k+1 cycles, update only in the last one
    task automatic squash_to(input logic [15:0] s, input logic mis, tk, input logic [31:0] tgt);
        @(negedge clk);
        squash_valid = 1; squash_seq = s; squash_mispred = mis;
        squash_taken = tk; squash_target = tgt;
        @(posedge clk); #1;
        squash_valid = 0;
        while (mq_seq.size() > 0 && mq_seq[$] > s) begin
            @(negedge clk);
            chk(squash_busy == 1'b1, "R7", {31'd0, squash_busy}, 32'd1);
            chk(dir_upd_valid == 1'b0, "R7", {31'd0, dir_upd_valid}, 32'd0);
            void'(mq_pc.pop_back()); void'(mq_tk.pop_back()); void'(mq_seq.pop_back());
        end
        @(negedge clk);
        chk(squash_busy == 1'b1, "R7", {31'd0, squash_busy}, 32'd1);
        if (mis && mq_pc.size() > 0) begin
            chk(dir_upd_valid && btb_upd_valid, "R8", {30'd0, dir_upd_valid, btb_upd_valid}, 32'd3);
            chk(dir_upd_pc == mq_pc[$] && btb_upd_pc == mq_pc[$], "R8", btb_upd_pc, mq_pc[$]);
            chk(dir_upd_taken == tk && btb_upd_target == tgt, "R8", btb_upd_target, tgt);
            void'(mq_pc.pop_back()); void'(mq_tk.pop_back()); void'(mq_seq.pop_back());
        end else begin
            chk(!dir_upd_valid && !btb_upd_valid, "R8", {30'd0, dir_upd_valid, btb_upd_valid}, 32'd0);
        end
        @(negedge clk);
        chk(squash_busy == 1'b0, "R7", {31'd0, squash_busy}, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc, a_pc, b_pc;
        logic [15:0] s0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        @(negedge clk);
        chk(!hist_full && !squash_busy, "R1", {30'd0, hist_full, squash_busy}, 32'd0);
        chk(!dir_upd_valid && !btb_upd_valid, "R1", {30'd0, dir_upd_valid, btb_upd_valid}, 32'd0);
        do_pred(32'h40, 0, 1, 0, 1, 0, 0, 0, 0, 32'd4, 32'd8, "R1");
        commit_to(seq_ctr - 1);

        // R3 sweep over call/direct/uncond/dir/btb-hit; fills the queue (R5)
        for (int p = 0; p < 32; p++) begin
            logic c, d, u, t, h, tk;
            logic [31:0] e, eds, dt, bt;
            c = p[0]; d = p[1]; u = p[2]; t = p[3]; h = p[4]; tk = u | t;
            pc = 32'h2000 + 32'(p) * 32'h40;
            dt = 32'h7000 + 32'(p); bt = 32'h5000 + 32'(p) * 4;
            if (!tk)          begin e = pc + 4; eds = pc + 8; end
            else if (c && d)  begin e = dt;     eds = dt;     end
            else if (h)       begin e = bt;     eds = bt;     end
            else              begin e = pc + 4; eds = pc + 8; end
            do_pred(pc, c, 0, d, u, t, h, bt, dt, e, eds, "R3");
        end
        @(negedge clk);
        chk(hist_full == 1'b1, "R5", {31'd0, hist_full}, 32'd1);
        // dropped call while full: must not reach the stack
        do_pred(32'hDEAD0, 1, 0, 1, 1, 0, 0, 0, 32'h10, 32'h10, 32'h10, "R5");
        commit_to(mq_seq[15]);
        commit_to(seq_ctr - 1);
        do_pred(32'h3000, 0, 1, 0, 1, 0, 0, 0, 0, 32'h2000 + 31*32'h40 + 4, 32'h2000 + 31*32'h40 + 8, "R5");
        do_pred(32'h3004, 0, 1, 0, 1, 0, 0, 0, 0, 32'h2000 + 29*32'h40 + 4, 32'h2000 + 29*32'h40 + 8, "R2");
        commit_to(seq_ctr - 1);

        // R4: 18 pushes wrap a 16-deep stack; 17 pops, last one stale
        for (int i = 0; i < 18; i++) begin
            pc = 32'h8000 + 32'(i) * 8;
            do_pred(pc, 1, 0, 1, 1, 0, 0, 0, 32'h100, 32'h100, 32'h100, "R2");
        end
        commit_to(seq_ctr - 1);
        for (int j = 0; j < 17; j++) begin
            pc = 32'h8000 + 32'(17 - (j % 16)) * 8;
            do_pred(32'hC000, 0, 1, 0, 1, 0, 0, 0, 0, pc + 4, pc + 8, "R4");
        end
        commit_to(seq_ctr - 1);

        // R7/R9: speculative calls/returns undone by squash
        a_pc = 32'h9000; b_pc = 32'h9100;
        do_pred(a_pc, 1, 0, 1, 1, 0, 0, 0, 32'h1, 32'h1, 32'h1, "R2");
        do_pred(b_pc, 1, 0, 1, 1, 0, 0, 0, 32'h1, 32'h1, 32'h1, "R2");
        commit_to(seq_ctr - 1);
        s0 = seq_ctr;
        do_pred(32'h9500, 0, 1, 0, 1, 0, 0, 0, 0, b_pc + 4, b_pc + 8, "R2");
        do_pred(32'h9200, 1, 0, 1, 1, 0, 0, 0, 32'h2, 32'h2, 32'h2, "R2");
        do_pred(32'h9504, 0, 1, 0, 1, 0, 0, 0, 0, 32'h9204, 32'h9208, "R2");
        do_pred(32'h9508, 0, 1, 0, 1, 0, 0, 0, 0, a_pc + 4, a_pc + 8, "R2");
        do_pred(32'h9300, 1, 0, 1, 1, 0, 0, 0, 32'h3, 32'h3, 32'h3, "R2");
        squash_to(s0, 0, 0, 0);
        do_pred(32'h950C, 0, 1, 0, 1, 0, 0, 0, 0, a_pc + 4, a_pc + 8, "R9");
        // mispredict: removes the return above, then updates entry s0
        squash_to(s0, 1, 1, 32'hABC0);
        do_pred(32'h9510, 0, 1, 0, 1, 0, 0, 0, 0, a_pc + 4, a_pc + 8, "R9");
        // squash with nothing younger: one busy cycle
        squash_to(seq_ctr + 16'd5, 0, 0, 0);
        commit_to(seq_ctr - 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule